// File: doc/BRIEF.md
# Paged Reference Floor Clamp

This block keeps a lower bound for a voltage reference code, one bound per channel, in two pages chosen by a page index. Every reference code request is checked against the bound of the active page, whether it comes from an explicit command or from loading a default. A code below the bound is raised to the bound and flagged as an invalid-data fault. A code at or above the bound passes through unchanged. The result is kept in a per-page output register.

The bound can be written and read through simple strobes. A write is range-checked and is refused while the controller runs in adaptive-voltage mode. A bulk restore load uses the same path and is also refused in that mode, but without any report. An invalid-data flag and an "other" communication flag drive an active-low alert. Both flags stay set until a clear strobe arrives.

Top module: `refloor_clamp_top`

## Requirements
- R1: After reset both page bounds and both reference codes equal 250, both flags are 0 and `alert_n` is 1.
- R2: `rd_data` shows the bound of the page selected by `page_sel`, zero-extended to 16 bits, in the same cycle. It does this in either mode.
- R3: In bus mode (`mode_avs`=0), a write whose low 10 bits lie in 250..750 stores those bits into the selected page's bound on the next clock. Bits 15:10 are ignored and the other page is unchanged.
- R4: In bus mode, a write whose low 10 bits lie outside 250..750 leaves the bound unchanged and sets `fault_ivd` on the next clock.
- R5: In adaptive-voltage mode (`mode_avs`=1), a write leaves both bounds unchanged, sets `status_oth` on the next clock and does not touch `fault_ivd`.
- R6: A restore load follows the rules of R3 and R4 in bus mode. In adaptive-voltage mode it changes nothing and sets no flag. When a write and a restore arrive in the same cycle, the write is used.
- R7: A request code at or above the active page's bound appears unchanged in that page's `ref_code` entry on the next clock. The other page's entry keeps its value.
- R8: A request code below the active page's bound stores the bound instead and sets `fault_ivd` on the next clock. This holds for command and default requests alike. The compare uses the bound as it stood before any same-cycle write.
- R9: When a command request and a default request arrive together, the command code is used.
- R10: `clear_faults` clears both flags on the next clock. A new fault event in the same cycle takes priority over the clear.
- R11: `alert_n` is 0 whenever either flag is set, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_sel | input | 1 | Active page/channel index |
| mode_avs | input | 1 | 1 = adaptive-voltage mode, 0 = bus mode |
| wr_en | input | 1 | Bound write strobe |
| wr_data | input | 16 | Bound write word (low 10 bits used) |
| rd_en | input | 1 | Bound read strobe (the data is always driven) |
| rd_data | output | 16 | Active page bound, zero-extended |
| restore_en | input | 1 | Bulk restore load strobe |
| restore_data | input | 16 | Restore word (low 10 bits used) |
| cmd_en | input | 1 | Explicit reference request strobe |
| cmd_code | input | 10 | Explicit requested code |
| dflt_en | input | 1 | Default-load reference request strobe |
| dflt_code | input | 10 | Default code |
| clear_faults | input | 1 | Clears both flags |
| ref_code | output | 2x10 | Registered reference code per page |
| fault_ivd | output | 1 | Invalid-data fault flag |
| status_oth | output | 1 | Refused-write communication flag |
| alert_n | output | 1 | Active-low alert |

## Verification
Requests are driven below, equal to and above the bound, from each source and from both together. This separates the clamp from the pass-through and also shows which source wins. The edge codes 249, 250, 750 and 751 are written with and without junk in the upper bits, in each mode and through both the write and restore paths. This separates a range rejection from a mode refusal and from a silent block. A request issued in the same cycle as a bound write shows whether the compare uses the old bound or the new one. A clear issued together with a fresh fault shows which of the two wins.

// File: rtl/refloor_pkg.sv
// Package: shared defaults and types for the paged reference floor clamp.
// Assumes: codes are unsigned, one LSB per 2 mV step.
package refloor_pkg;
    localparam int DEF_CODE_W    = 10;
    localparam int DEF_WORD_W    = 16;
    localparam int DEF_N_PAGES   = 2;
    localparam int DEF_FLOOR_MIN = 250;
    localparam int DEF_FLOOR_MAX = 750;

    // Outcome of a bound load attempt, for internal decode.
    typedef enum logic [1:0] {
        LOAD_NONE    = 2'd0,
        LOAD_ACCEPT  = 2'd1,
        LOAD_RANGE   = 2'd2,
        LOAD_REFUSED = 2'd3
    } load_result_e;
endpackage

// File: rtl/floor_bank.sv
// Module: floor_bank
// Holds one lower-bound code per page. Picks the load source (a write has
// priority over a restore), range-checks the code and applies mode gating.
// It reports range errors and refused writes as single-cycle events.
// Assumes: N_PAGES is a power of two so page_sel always addresses a page.
module floor_bank #(
    parameter int CODE_W    = refloor_pkg::DEF_CODE_W,
    parameter int WORD_W    = refloor_pkg::DEF_WORD_W,
    parameter int N_PAGES   = refloor_pkg::DEF_N_PAGES,
    parameter int PAGE_W    = 1,
    parameter int FLOOR_MIN = refloor_pkg::DEF_FLOOR_MIN,
    parameter int FLOOR_MAX = refloor_pkg::DEF_FLOOR_MAX
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [PAGE_W-1:0]               page_sel,
    input  logic                            mode_avs,
    input  logic                            wr_en,
    input  logic [WORD_W-1:0]               wr_data,
    input  logic                            restore_en,
    input  logic [WORD_W-1:0]               restore_data,
    output logic [N_PAGES-1:0][CODE_W-1:0]  floor_q,
    output logic [CODE_W-1:0]               active_floor,
    output logic                            ev_range_err,
    output logic                            ev_mode_block
);
    import refloor_pkg::*;

    localparam logic [CODE_W-1:0] MIN_C = CODE_W'(FLOOR_MIN);
    localparam logic [CODE_W-1:0] MAX_C = CODE_W'(FLOOR_MAX);

    logic [WORD_W-1:0] load_word;
    logic [CODE_W-1:0] load_code;
    logic              load_req;
    logic              in_range;
    load_result_e      load_res;
    logic              unused_upper;

    // Select the load source and classify the attempt.
    always_comb begin
        load_req  = wr_en | restore_en;
        load_word = wr_en ? wr_data : restore_data;
        load_code = load_word[CODE_W-1:0];
        in_range  = (load_code >= MIN_C) && (load_code <= MAX_C);
        if (!load_req)
            load_res = LOAD_NONE;
        else if (mode_avs)
            load_res = wr_en ? LOAD_REFUSED : LOAD_NONE;
        else if (in_range)
            load_res = LOAD_ACCEPT;
        else
            load_res = LOAD_RANGE;
    end

    assign unused_upper  = ^load_word[WORD_W-1:CODE_W];
    assign ev_range_err  = (load_res == LOAD_RANGE);
    assign ev_mode_block = (load_res == LOAD_REFUSED);
    assign active_floor  = floor_q[page_sel];

    // One bound register per page, loaded only on an accepted attempt.
    for (genvar p = 0; p < N_PAGES; p++) begin : g_page
        always_ff @(posedge clk) begin
            if (!rst_n)
                floor_q[p] <= MIN_C;
            else if ((load_res == LOAD_ACCEPT) && (page_sel == PAGE_W'(p)))
                floor_q[p] <= load_code;
        end

        assert_floor_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (floor_q[p] >= MIN_C) && (floor_q[p] <= MAX_C));
    end

    assert_mode_freezes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_avs |=> $stable(floor_q));

    assert_bad_code_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && !mode_avs && !in_range) |=> $stable(floor_q));
endmodule

// File: rtl/ref_clamp.sv
// Module: ref_clamp
// Merges the command and default requests (the command has priority) and
// raises any code below the active bound to that bound. It stores the result
// in the active page's output register and flags the clamp as an event.
// Assumes: active_floor is the bound registered before this cycle.
module ref_clamp #(
    parameter int CODE_W    = refloor_pkg::DEF_CODE_W,
    parameter int N_PAGES   = refloor_pkg::DEF_N_PAGES,
    parameter int PAGE_W    = 1,
    parameter int RESET_CODE = refloor_pkg::DEF_FLOOR_MIN
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [PAGE_W-1:0]               page_sel,
    input  logic [CODE_W-1:0]               active_floor,
    input  logic                            cmd_en,
    input  logic [CODE_W-1:0]               cmd_code,
    input  logic                            dflt_en,
    input  logic [CODE_W-1:0]               dflt_code,
    output logic [N_PAGES-1:0][CODE_W-1:0]  ref_q,
    output logic                            ev_clamp
);
    logic              req_any;
    logic [CODE_W-1:0] req_code;
    logic [CODE_W-1:0] out_code;

    // Merge the request sources and apply the lower bound.
    always_comb begin
        req_any  = cmd_en | dflt_en;
        req_code = cmd_en ? cmd_code : dflt_code;
        ev_clamp = req_any && (req_code < active_floor);
        out_code = ev_clamp ? active_floor : req_code;
    end

    // One output register per page, written only when that page is active.
    for (genvar p = 0; p < N_PAGES; p++) begin : g_page
        always_ff @(posedge clk) begin
            if (!rst_n)
                ref_q[p] <= CODE_W'(RESET_CODE);
            else if (req_any && (page_sel == PAGE_W'(p)))
                ref_q[p] <= out_code;
        end

        assert_not_below_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (req_any && page_sel == PAGE_W'(p)) |=> (ref_q[p] >= $past(active_floor)));

        assert_other_page_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (page_sel != PAGE_W'(p)) |=> $stable(ref_q[p]));
    end
endmodule

// File: rtl/fault_flags.sv
// Module: fault_flags
// Sticky invalid-data and refused-write flags plus the active-low alert.
// A new event takes priority over a clear in the same cycle.
// Assumes: event inputs are single-cycle pulses from the same clock domain.
module fault_flags #(
    parameter int N_IVD_SRC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_IVD_SRC-1:0] ev_ivd,
    input  logic                 ev_oth,
    input  logic                 clear,
    output logic                 ivd_q,
    output logic                 oth_q,
    output logic                 alert_n
);
    logic any_ivd;

    // Collapse all invalid-data sources into one event.
    always_comb any_ivd = |ev_ivd;

    // Set-dominant sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ivd_q <= 1'b0;
            oth_q <= 1'b0;
        end else begin
            if (any_ivd)     ivd_q <= 1'b1;
            else if (clear)  ivd_q <= 1'b0;
            if (ev_oth)      oth_q <= 1'b1;
            else if (clear)  oth_q <= 1'b0;
        end
    end

    // Alert follows the flags.
    always_comb alert_n = ~(ivd_q | oth_q);

    assert_ivd_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        any_ivd |=> ivd_q);

    assert_clear_works_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !any_ivd && !ev_oth) |=> (!ivd_q && !oth_q && alert_n));

    assert_oth_alerts_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_oth |=> !alert_n);
endmodule

// File: rtl/refloor_clamp_top.sv
// Module: refloor_clamp_top
// Paged reference floor clamp: bound storage with range and mode gating,
// request clamping per page, and sticky fault reporting with an alert.
// Assumes: all inputs are synchronous to clk; N_PAGES is a power of two.
module refloor_clamp_top #(
    parameter int CODE_W    = refloor_pkg::DEF_CODE_W,
    parameter int WORD_W    = refloor_pkg::DEF_WORD_W,
    parameter int N_PAGES   = refloor_pkg::DEF_N_PAGES,
    parameter int FLOOR_MIN = refloor_pkg::DEF_FLOOR_MIN,
    parameter int FLOOR_MAX = refloor_pkg::DEF_FLOOR_MAX,
    localparam int PAGE_W   = (N_PAGES > 1) ? $clog2(N_PAGES) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [PAGE_W-1:0]               page_sel,
    input  logic                            mode_avs,
    input  logic                            wr_en,
    input  logic [WORD_W-1:0]               wr_data,
    input  logic                            rd_en,
    output logic [WORD_W-1:0]               rd_data,
    input  logic                            restore_en,
    input  logic [WORD_W-1:0]               restore_data,
    input  logic                            cmd_en,
    input  logic [CODE_W-1:0]               cmd_code,
    input  logic                            dflt_en,
    input  logic [CODE_W-1:0]               dflt_code,
    input  logic                            clear_faults,
    output logic [N_PAGES-1:0][CODE_W-1:0]  ref_code,
    output logic                            fault_ivd,
    output logic                            status_oth,
    output logic                            alert_n
);
    logic [N_PAGES-1:0][CODE_W-1:0] floor_q;
    logic [CODE_W-1:0]              active_floor;
    logic                           ev_range_err;
    logic                           ev_mode_block;
    logic                           ev_clamp;
    logic                           unused_rd;

    floor_bank #(
        .CODE_W(CODE_W), .WORD_W(WORD_W), .N_PAGES(N_PAGES), .PAGE_W(PAGE_W),
        .FLOOR_MIN(FLOOR_MIN), .FLOOR_MAX(FLOOR_MAX)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .mode_avs(mode_avs),
        .wr_en(wr_en), .wr_data(wr_data), .restore_en(restore_en),
        .restore_data(restore_data), .floor_q(floor_q), .active_floor(active_floor),
        .ev_range_err(ev_range_err), .ev_mode_block(ev_mode_block)
    );

    ref_clamp #(
        .CODE_W(CODE_W), .N_PAGES(N_PAGES), .PAGE_W(PAGE_W), .RESET_CODE(FLOOR_MIN)
    ) u_clamp (
        .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .active_floor(active_floor),
        .cmd_en(cmd_en), .cmd_code(cmd_code), .dflt_en(dflt_en), .dflt_code(dflt_code),
        .ref_q(ref_code), .ev_clamp(ev_clamp)
    );

    fault_flags #(.N_IVD_SRC(2)) u_flags (
        .clk(clk), .rst_n(rst_n), .ev_ivd({ev_clamp, ev_range_err}),
        .ev_oth(ev_mode_block), .clear(clear_faults),
        .ivd_q(fault_ivd), .oth_q(status_oth), .alert_n(alert_n)
    );

    // Read path: the strobe only qualifies the data, which is always driven.
    assign rd_data   = {{(WORD_W-CODE_W){1'b0}}, active_floor};
    assign unused_rd = rd_en;

    assert_read_zero_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WORD_W-1:CODE_W] == '0);

    assert_read_tracks_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !mode_avs && !ev_range_err) |=>
            (floor_q[$past(page_sel)] == $past(wr_data[CODE_W-1:0])));
endmodule

// File: tb/test_refloor_clamp_top.sv
module test_refloor_clamp_top;
    logic              clk = 0;
    logic              rst_n = 0;
    logic [0:0]        page_sel = 0;
    logic              mode_avs = 0, wr_en = 0, rd_en = 0, restore_en = 0;
    logic              cmd_en = 0, dflt_en = 0, clear_faults = 0;
    logic [15:0]       wr_data = 0, restore_data = 0, rd_data;
    logic [9:0]        cmd_code = 0, dflt_code = 0;
    logic [1:0][9:0]   ref_code;
    logic              fault_ivd, status_oth, alert_n;

    int errors = 0, checks = 0;
    int floor_m [2];
    int ref_m [2];
    int ivd_m, oth_m;
    bit done = 0;

    always #5 clk = ~clk;

    refloor_clamp_top i_refloor_clamp_top (
        .clk(clk), .rst_n(rst_n), .page_sel(page_sel), .mode_avs(mode_avs),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .restore_en(restore_en), .restore_data(restore_data),
        .cmd_en(cmd_en), .cmd_code(cmd_code), .dflt_en(dflt_en), .dflt_code(dflt_code),
        .clear_faults(clear_faults), .ref_code(ref_code), .fault_ivd(fault_ivd),
        .status_oth(status_oth), .alert_n(alert_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every registered output with the model.
    task automatic compare_all(input string tag);
        chk({tag, " ref0"}, ref_code[0], ref_m[0]);
        chk({tag, " ref1"}, ref_code[1], ref_m[1]);
        chk({tag, " ivd"}, fault_ivd, ivd_m);
        chk({tag, " oth"}, status_oth, oth_m);
        chk("R11 alert", alert_n, (ivd_m || oth_m) ? 0 : 1);
    endtask

    // One clock: read check, model next state, edge, compare, release strobes.
    task automatic step(input string tag);
        int pg, c, code, ev_ivd, ev_oth, nfl, nref, ref_pg;
        bit ref_upd;
        pg = page_sel; ev_ivd = 0; ev_oth = 0; nfl = floor_m[pg]; ref_upd = 0; nref = 0;
        #1;
        if (rd_en) chk({tag, " R2 read"}, rd_data, floor_m[pg]);
        if (wr_en) begin
            if (mode_avs) ev_oth = 1;
            else begin
                c = wr_data & 1023;
                if (c >= 250 && c <= 750) nfl = c; else ev_ivd = 1;
            end
        end else if (restore_en && !mode_avs) begin
            c = restore_data & 1023;
            if (c >= 250 && c <= 750) nfl = c; else ev_ivd = 1;
        end
        if (cmd_en || dflt_en) begin
            code = cmd_en ? cmd_code : dflt_code;
            ref_upd = 1;
            if (code < floor_m[pg]) begin nref = floor_m[pg]; ev_ivd = 1; end
            else nref = code;
        end
        ref_pg = pg;
        @(posedge clk);
        #2;
        floor_m[pg] = nfl;
        if (ref_upd) ref_m[ref_pg] = nref;
        if (ev_ivd) ivd_m = 1; else if (clear_faults) ivd_m = 0;
        if (ev_oth) oth_m = 1; else if (clear_faults) oth_m = 0;
        compare_all(tag);
        wr_en = 0; rd_en = 0; restore_en = 0; cmd_en = 0; dflt_en = 0; clear_faults = 0;
    endtask

    task automatic rd(input int pg, input string tag);
        page_sel = pg[0:0]; rd_en = 1; step(tag);
    endtask

    task automatic wr(input int pg, input int d, input string tag);
        page_sel = pg[0:0]; wr_en = 1; wr_data = d[15:0]; step(tag);
    endtask

    task automatic rs(input int pg, input int d, input string tag);
        page_sel = pg[0:0]; restore_en = 1; restore_data = d[15:0]; step(tag);
    endtask

    task automatic cmd(input int pg, input int d, input string tag);
        page_sel = pg[0:0]; cmd_en = 1; cmd_code = d[9:0]; step(tag);
    endtask

    task automatic dflt(input int pg, input int d, input string tag);
        page_sel = pg[0:0]; dflt_en = 1; dflt_code = d[9:0]; step(tag);
    endtask

    task automatic clr(input string tag);
        clear_faults = 1; step(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        floor_m[0] = 250; floor_m[1] = 250; ref_m[0] = 250; ref_m[1] = 250;
        ivd_m = 0; oth_m = 0;
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        // R1: reset state
        compare_all("R1");
        rd(0, "R1"); rd(1, "R1");
        // R3: legal writes, page isolation, upper bits ignored
        wr(0, 400, "R3"); rd(0, "R3"); rd(1, "R3");
        wr(1, 16'hFC00 | 750, "R3"); rd(1, "R3");
        wr(0, 250, "R3"); wr(0, 400, "R3"); rd(0, "R3");
        // R4: out-of-range writes
        wr(0, 249, "R4"); rd(0, "R4");
        wr(0, 751, "R4"); wr(0, 16'hFC00 | 100, "R4"); rd(0, "R4");
        clr("R10");
        // R5: refused write in adaptive mode, reads still work
        mode_avs = 1;
        wr(0, 500, "R5"); rd(0, "R5 R2");
        // R10: clear together with a new clamp fault, then clear alone
        page_sel = 0; cmd_en = 1; cmd_code = 10'd100; clear_faults = 1; step("R10");
        clr("R10");
        // R6: restore blocked silently in adaptive mode, applied in bus mode
        rs(1, 300, "R6"); rd(1, "R6");
        mode_avs = 0;
        rs(1, 300, "R6"); rd(1, "R6");
        rs(1, 100, "R6"); rd(1, "R6");
        clr("R10");
        page_sel = 0; wr_en = 1; wr_data = 16'd600; restore_en = 1; restore_data = 16'd300;
        step("R6"); rd(0, "R6");
        wr(0, 400, "R3");
        // R7: pass-through at and above bound
        cmd(0, 600, "R7"); cmd(0, 400, "R7"); dflt(1, 500, "R7"); dflt(1, 300, "R7");
        // R8: clamp from both sources
        cmd(0, 100, "R8"); clr("R10");
        dflt(1, 200, "R8"); clr("R10");
        cmd(1, 299, "R8"); clr("R10");
        mode_avs = 1; dflt(0, 0, "R8"); clr("R10"); mode_avs = 0;
        // R9: command wins over default
        page_sel = 0; cmd_en = 1; cmd_code = 10'd700; dflt_en = 1; dflt_code = 10'd100; step("R9");
        page_sel = 0; cmd_en = 1; cmd_code = 10'd100; dflt_en = 1; dflt_code = 10'd700; step("R9");
        clr("R10");
        // R8: compare uses the bound before a same-cycle write
        page_sel = 0; wr_en = 1; wr_data = 16'd700; cmd_en = 1; cmd_code = 10'd500; step("R8");
        rd(0, "R8");
        cmd(0, 500, "R8");
        // R5 with flags then clear
        mode_avs = 1; wr(1, 400, "R5"); mode_avs = 0; clr("R10");
        rd(1, "R2");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule